// File: doc/BRIEF.md
# Per-Record Multi-Width Serial Shifter

This block runs a serial flash-style link under control of a queue of 21-bit records. Each record holds up to sixteen bits of payload and its own settings: lane count (one, two or four data lines), payload size (one or two bytes), whether the active lines drive during the record, and whether the bits sampled back are kept. Records are written into an internal transmit queue. The engine takes them one at a time, produces the serial clock from a fixed divider, and moves the payload out on the data lines. At the same time it samples the same number of bits back. Sampled words land in an internal receive queue that the host drains.

Settings may differ from one record to the next. A transfer can therefore open with a command byte on one line whose sampled bits are discarded, then send address bytes on four driven lines, then read data on four undriven lines. The engine never starts a record whose result would have to be stored while the receive queue is full. It waits instead, so no data is lost. The chip-select output stays asserted for as long as work is pending.

Top module: `spi_lane_engine`

## Requirements
- R1: A record holds payload in bits [15:0], a lane code in [17:16], a size flag in [18] (0 = one byte, 1 = two bytes), a drive flag in [19] and a discard flag in [20].
- R2: Lane code 0 uses one line, 1 uses two lines and 2 uses four lines. Code 3 behaves as code 0. Bits of each byte leave most significant first: one line sends one bit on sd_out[0], two lines send bits [7:6] on sd_out[1:0], four lines send bits [7:4] on sd_out[3:0].
- R3: With the size flag 0, only payload[7:0] is sent, and the stored word is the sampled byte in [7:0] with zeros in [15:8]. With the flag 1, all sixteen bits are sent and sixteen bits are stored.
- R4: In two-byte records, payload[7:0] is sent before payload[15:8], and the first byte sampled becomes bits [7:0] of the stored word.
- R5: During a one-line record, sd_oe is 4'b0001. During a two-line record it is 4'b0011 if the drive flag is set, otherwise 4'b0000. During a four-line record it is 4'b1111 if the drive flag is set, otherwise 4'b0000. sd_oe does not change while sck is high.
- R6: sck is low whenever the block is idle. Each sck half-period lasts HALF_DIV system clocks.
- R7: sd_out changes only while sck is low. The first bits of a record are present before its first rising sck edge.
- R8: Input lines are sampled at each rising sck edge. One-line records read sd_in[1], two-line records read sd_in[1:0] and four-line records read sd_in[3:0], with the first bit of each byte in the highest lane.
- R9: A record with the discard flag set is shifted normally, and no word enters the receive queue.
- R10: A record that needs to store a word does not start while the receive queue is full. A record with the discard flag set may start even then.
- R11: busy is high while a record is shifting, its word is being stored, or the transmit queue holds records. cs_n is the inverse of busy.
- R12: Records with different lane codes, sizes and drive flags may follow one another, and each is shifted with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Write one record into the transmit queue |
| tx_data | input | 21 | Record to write |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head word of the receive queue |
| rx_data | output | 16 | Head word of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Work pending or in progress |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| sd_out | output | 4 | Data line output values |
| sd_oe | output | 4 | Per-line output enables |
| sd_in | input | 4 | Data line input values |

## Verification
On every cycle the assertions check the line-timing rules: sck is low when idle, output data and enables move only while sck is low, sd_oe takes only legal patterns, chip select is asserted at every rising sck edge, and no word is stored into a full receive queue. Bit order, lane mapping, byte order within a stored word, discarding, and correct decoding of each record's settings can only be shown by the bench's scenarios. The bench acts as a serial device, drives known bits on the input lines and compares both directions against the expected streams. The stall while the queue is full, the discard record that may pass during a stall, and the sck period are likewise shown by directed scenarios.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int REC_W  = 21;
  localparam int WORD_W = 16;
  localparam int LANES  = 4;

  typedef struct packed {
    logic        discard;
    logic        drive;
    logic        wide;
    logic [1:0]  lanes;
    logic [15:0] payload;
  } rec_t;
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire do_wr = wr && !full;
  wire do_rd = rd && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_avail,
  input  rec_t              rec,
  input  logic              rx_full,
  output logic              rec_take,
  output logic              rx_wr,
  output logic [WORD_W-1:0] rx_word,
  output logic              shifting,
  output logic              sck,
  output logic [LANES-1:0]  sd_out,
  output logic [LANES-1:0]  sd_oe,
  input  logic [LANES-1:0]  sd_in
);
  localparam int CW = $clog2(HALF_DIV) + 1;

  logic [CW-1:0]     cnt;
  logic [4:0]        pulses_left;
  logic [1:0]        mode_q;
  logic              wide_q, discard_q;
  logic [WORD_W-1:0] tx_sh, rx_sh;

  // decode of the record at the queue head
  logic [1:0]        mode_d;
  logic [WORD_W-1:0] word_d;
  logic [LANES-1:0]  oe_d;
  logic              start;

  function automatic logic [LANES-1:0] head_bits(logic [WORD_W-1:0] w, logic [1:0] m);
    case (m)
      2'd1:    return {2'b00, w[15:14]};
      2'd2:    return w[15:12];
      default: return {3'b000, w[15]};
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] shift_on(logic [WORD_W-1:0] w, logic [1:0] m);
    case (m)
      2'd1:    return w << 2;
      2'd2:    return w << 4;
      default: return w << 1;
    endcase
  endfunction

  always_comb begin
    mode_d = (rec.lanes == 2'd3) ? 2'd0 : rec.lanes;
    word_d = rec.wide ? {rec.payload[7:0], rec.payload[15:8]}
                      : {rec.payload[7:0], 8'h00};
    case (mode_d)
      2'd1:    oe_d = rec.drive ? 4'b0011 : 4'b0000;
      2'd2:    oe_d = rec.drive ? 4'b1111 : 4'b0000;
      default: oe_d = 4'b0001;
    endcase
  end

  assign start    = !shifting && !rx_wr && rec_avail && (rec.discard || !rx_full);
  assign rec_take = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      shifting    <= 1'b0;
      cnt         <= '0;
      pulses_left <= '0;
      mode_q      <= '0;
      wide_q      <= 1'b0;
      discard_q   <= 1'b0;
      tx_sh       <= '0;
      rx_sh       <= '0;
      rx_wr       <= 1'b0;
      rx_word     <= '0;
      sck         <= 1'b0;
      sd_out      <= '0;
      sd_oe       <= '0;
    end else begin
      rx_wr <= 1'b0;
      if (start) begin
        shifting    <= 1'b1;
        sck         <= 1'b0;
        cnt         <= CW'(HALF_DIV - 1);
        mode_q      <= mode_d;
        wide_q      <= rec.wide;
        discard_q   <= rec.discard;
        pulses_left <= (rec.wide ? 5'd16 : 5'd8) >> mode_d;
        tx_sh       <= word_d;
        rx_sh       <= '0;
        sd_out      <= head_bits(word_d, mode_d);
        sd_oe       <= oe_d;
      end else if (shifting) begin
        if (cnt == '0) begin
          cnt <= CW'(HALF_DIV - 1);
          sck <= !sck;
          if (!sck) begin
            case (mode_q)
              2'd1:    rx_sh <= {rx_sh[13:0], sd_in[1:0]};
              2'd2:    rx_sh <= {rx_sh[11:0], sd_in[3:0]};
              default: rx_sh <= {rx_sh[14:0], sd_in[1]};
            endcase
          end else if (pulses_left == 5'd1) begin
            shifting    <= 1'b0;
            pulses_left <= '0;
            sd_oe       <= '0;
            rx_wr       <= !discard_q;
            rx_word     <= wide_q ? {rx_sh[7:0], rx_sh[15:8]} : {8'h00, rx_sh[7:0]};
          end else begin
            pulses_left <= pulses_left - 1'b1;
            tx_sh       <= shift_on(tx_sh, mode_q);
            sd_out      <= head_bits(shift_on(tx_sh, mode_q), mode_q);
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_lane_engine.sv
module spi_lane_engine
  import spi_eng_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_push,
  input  logic [20:0]  tx_data,
  output logic         tx_full,
  input  logic         rx_pop,
  output logic [15:0]  rx_data,
  output logic         rx_empty,
  output logic         busy,
  output logic         cs_n,
  output logic         sck,
  output logic [3:0]   sd_out,
  output logic [3:0]   sd_oe,
  input  logic [3:0]   sd_in
);
  logic [REC_W-1:0]  head_raw;
  logic              tx_empty, take;
  logic              rx_wr_i, rx_full_i, shifting;
  logic [WORD_W-1:0] rx_word;

  spi_eng_fifo #(.W(REC_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .wr(tx_push), .wdata(tx_data),
    .rd(take), .rdata(head_raw), .full(tx_full), .empty(tx_empty)
  );

  spi_eng_shift #(.HALF_DIV(HALF_DIV)) u_core (
    .clk(clk), .rst(rst), .rec_avail(!tx_empty), .rec(rec_t'(head_raw)),
    .rx_full(rx_full_i), .rec_take(take), .rx_wr(rx_wr_i), .rx_word(rx_word),
    .shifting(shifting), .sck(sck), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  spi_eng_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr(rx_wr_i), .wdata(rx_word),
    .rd(rx_pop), .rdata(rx_data), .full(rx_full_i), .empty(rx_empty)
  );

  assign busy = shifting || rx_wr_i || !tx_empty;
  assign cs_n = !busy;
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] sd_out,
  input logic [3:0] sd_oe,
  input logic       rx_wr,
  input logic       rx_full
);
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  a_r11_cs_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> !cs_n);
  a_r7_out_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out) |-> !sck);
  a_r5_oe_steady_high: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(sd_oe));
  a_r5_oe_legal: assert property (@(posedge clk) disable iff (rst)
    (sd_oe == 4'b0000) || (sd_oe == 4'b0001) || (sd_oe == 4'b0011) || (sd_oe == 4'b1111));
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    rx_wr |-> !rx_full);
endmodule

bind spi_lane_engine spi_eng_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .cs_n(cs_n), .sck(sck),
  .sd_out(sd_out), .sd_oe(sd_oe), .rx_wr(rx_wr_i), .rx_full(rx_full_i)
);

// File: tb/sim_spi_lane_engine.sv
module sim_spi_lane_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HD = 2;
  localparam int NV = 8;
  // {record[20:0], device word[15:0]}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 16'h77A5, 16'h993C},
    {1'b0, 1'b0, 1'b1, 2'd0, 16'h1234, 16'hBEEF},
    {1'b0, 1'b1, 1'b0, 2'd1, 16'h00C6, 16'h005A},
    {1'b0, 1'b0, 1'b1, 2'd1, 16'hF00D, 16'h8421},
    {1'b0, 1'b1, 1'b0, 2'd2, 16'h0096, 16'h00E7},
    {1'b0, 1'b0, 1'b1, 2'd2, 16'hCAFE, 16'h1357},
    {1'b0, 1'b1, 1'b1, 2'd3, 16'h0F0F, 16'hA55A},
    {1'b1, 1'b1, 1'b0, 2'd2, 16'h009F, 16'h0011}
  };

  logic clk = 0, rst = 1;
  logic tx_push = 0, rx_pop = 0;
  logic [20:0] tx_data = '0;
  logic [3:0] sd_in = '0;
  logic tx_full, rx_empty, busy, cs_n, sck;
  logic [15:0] rx_data;
  logic [3:0] sd_out, sd_oe;
  int checks = 0, fails = 0, cyc = 0;

  spi_lane_engine #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rst(rst), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .busy(busy),
    .cs_n(cs_n), .sck(sck), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int lane_n(logic [1:0] code);
    return (code == 2'd1) ? 2 : (code == 2'd2) ? 4 : 1;
  endfunction

  // bits of pulse k: stream bit i = byte i/8, bit 7-(i%8), first bit in top lane
  function automatic logic [3:0] lanes_exp(logic [15:0] w, int n, int k);
    logic [3:0] r = '0;
    for (int j = 0; j < n; j++) begin
      int i = k * n + j;
      if (i < 16) r[n-1-j] = w[(i/8)*8 + 7 - (i%8)];
    end
    return r;
  endfunction

  function automatic logic [3:0] dev_drive(logic [15:0] w, int n, int k);
    logic [3:0] v = lanes_exp(w, n, k);
    return (n == 1) ? {2'b00, v[0], 1'b0} : v;
  endfunction

  task automatic push_rec(input logic [20:0] r);
    @(negedge clk);
    tx_push = 1; tx_data = r;
    @(negedge clk);
    tx_push = 0;
  endtask

  task automatic pop_word(output logic [15:0] w);
    w = rx_data;
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_rec(input logic [20:0] r, input logic [15:0] dev);
    int n = lane_n(r[17:16]);
    int pulses = (r[18] ? 16 : 8) / n;
    logic [3:0] mask = (n == 4) ? 4'hF : (n == 2) ? 4'h3 : 4'h1;
    logic [3:0] oe_exp = (n == 1) ? 4'b0001 : (r[19] ? mask : 4'b0000);
    int tx_bad = 0, oe_bad = 0;
    logic [3:0] bad_act = '0, bad_exp = '0;
    logic [15:0] got;
    logic [15:0] rx_exp = r[18] ? dev : {8'h00, dev[7:0]};
    sd_in = dev_drive(dev, n, 0);
    push_rec(r);
    for (int k = 0; k < pulses; k++) begin
      while (sck) @(negedge clk);
      while (!sck) @(negedge clk);
      if ((sd_out & mask) !== lanes_exp(r[15:0], n, k)) begin
        tx_bad++; bad_act = sd_out & mask; bad_exp = lanes_exp(r[15:0], n, k);
      end
      if (sd_oe !== oe_exp) oe_bad++;
      sd_in = dev_drive(dev, n, k + 1);
    end
    wait_idle();
    // R2 R4 R12: serial out order and lanes
    check(tx_bad == 0, "R2/R4/R12 out bits", {28'h0, bad_act}, {28'h0, bad_exp});
    check(oe_bad == 0, "R5 enables", {28'h0, sd_oe}, {28'h0, oe_exp});
    if (r[20]) begin
      check(rx_empty === 1'b1, "R9 discard", {31'h0, rx_empty}, 32'h1);
    end else begin
      check(rx_empty === 1'b0, "R8 stored", {31'h0, rx_empty}, 32'h0);
      pop_word(got);
      check(got === rx_exp, "R3/R8 sampled word", {16'h0, got}, {16'h0, rx_exp});
    end
  endtask

  initial begin
    logic [15:0] w;
    int t0, gap;
    logic rose;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    check(!busy && cs_n && !sck && sd_oe == 0, "R11 reset idle", {28'h0, busy, cs_n, sck, 1'b0}, 32'h4);
    check(rx_empty && !tx_full, "R11 reset queues", {30'h0, rx_empty, tx_full}, 32'h2);

    // R1 R12: table of mixed records
    for (int v = 0; v < NV; v++) run_rec(VEC[v][36:16], VEC[v][15:0]);

    // R6: sck period and high time
    sd_in = '0;
    push_rec({1'b1, 1'b0, 1'b0, 2'd0, 16'h00AA});
    while (!sck) @(negedge clk);
    t0 = cyc;
    while (sck) @(negedge clk);
    check(cyc - t0 == HD, "R6 high time", cyc - t0, HD);
    while (!sck) @(negedge clk);
    gap = cyc - t0;
    check(gap == 2 * HD, "R6 period", gap, 2 * HD);
    wait_idle();
    check(!sck && cs_n, "R6/R11 idle after record", {30'h0, sck, cs_n}, 32'h1);

    // R7: first bits present before first rise, while sck low
    push_rec({1'b1, 1'b1, 1'b0, 2'd2, 16'h00B0});
    @(negedge clk); @(negedge clk);
    check(!sck && sd_out == 4'hB && sd_oe == 4'hF, "R7 first bits early",
          {27'h0, sck, sd_out}, 32'hB);
    wait_idle();

    // R10: fill receive queue, discard record still passes, stored record stalls
    sd_in = 4'hF;
    for (int i = 0; i < 4; i++) begin
      push_rec({1'b0, 1'b1, 1'b0, 2'd2, 16'h0055});
      wait_idle();
    end
    push_rec({1'b1, 1'b1, 1'b0, 2'd2, 16'h0033});
    wait_idle();
    check(!busy, "R10 discard runs while full", {31'h0, busy}, 32'h0);
    push_rec({1'b0, 1'b1, 1'b0, 2'd2, 16'h0066});
    rose = 0;
    repeat (40) begin
      @(negedge clk);
      if (sck) rose = 1;
    end
    check(!rose && busy && !cs_n, "R10/R11 stall when full", {30'h0, rose, busy}, 32'h1);
    pop_word(w);
    check(w == 16'h00FF, "R10 stored word", {16'h0, w}, 32'h00FF);
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      check(!rx_empty, "R10 nothing dropped", {31'h0, rx_empty}, 32'h0);
      pop_word(w);
    end
    check(rx_empty, "R10 queue drained", {31'h0, rx_empty}, 32'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule